// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

This block takes 24 interrupt request lines from on-chip peripherals and places each one on one of the nine general-purpose priority inputs of a core event controller. Those inputs are levels 7 through 15. Every source has a 4-bit target field in a small bank of memory-mapped assignment words. Software can rewrite a field at any time to move a source to another level. Several sources may target the same level. Each level output is the logical OR of every source that currently targets it.

After reset the fields hold a fixed default routing:

| Level | Sources |
|---|---|
| 7 | sources 0–6: the clock-generator wakeup, the DMA fault and the five peripheral error lines |
| 8 | sources 7–8: the real-time clock and DMA channel 0 |
| 9 | sources 9–12: DMA channels 1–4 |
| 10 | sources 13–15: DMA channels 5–7 |
| 11 | sources 16–18: the three timers |
| 12 | sources 19–20: the two GPIO lines |
| 13 | sources 21–23: the two memory-to-memory DMA streams and the watchdog |

A read-only status word returns the raw state of all 24 request inputs. The level outputs are combinational in the sources and in the stored fields, so a request reaches its level in the same cycle. Priority resolution between levels is done downstream.

Top module: `irq_router`

## Requirements
- R1: After reset, assignment word 0 reads 0x1000_0000, word 1 reads 0x3332_2221 and word 2 reads 0x6665_5444. These values give the default routing in the table above.
- R2: A write to word address 0, 1 or 2 replaces all eight fields of that word. Source s lives in word s/8 at bits [4*(s%8)+3 : 4*(s%8)]. The written value reads back from the next cycle on.
- R3: Output bit k of `lvl_irq` stands for level k+7. A field value v in 0..8 routes its source to bit v. With one source active, exactly the bit given by its field is high.
- R4: Any number of sources may share a level. That level's output stays high while at least one of its assigned sources is high, and no level is high when no source is high.
- R5: A field change takes effect at the clock edge that performs the write. During the write cycle the outputs still follow the old routing, and from the next cycle they follow the new one.
- R6: A source whose field holds a value from 9 to 15 drives no level at all.
- R7: Reading word address 3 returns the 24 source inputs in bits 23:0, with bit s equal to source s, and zeros above.
- R8: Writes to word address 3 are ignored: all assignment words and all routing stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address (0–2 assignment, 3 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| src_irq | input | 24 | Peripheral interrupt requests, level-sensitive |
| lvl_irq | output | 9 | Requests to levels 7..15, bit k = level k+7 |

## Verification
The bench walks each source alone through the default map. A field slip in the default table or in the nibble packing would light the wrong level for that source. It moves a source while the source is active and samples both before and after the write edge. An output stage that is registered, or that is driven from the write bus, would show the new level too late or too early. Field values 9 to 15 are written to confirm they route nowhere; a design that truncated the field would wrap such a source onto a real level. A write to the status address is checked for silence, because an address decoder that aliases that address onto word 0 would corrupt the routing.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    parameter int unsigned SRC_N  = 24;
    parameter int unsigned LVL_N  = 9;
    parameter int unsigned FLD_W  = 4;
    parameter int unsigned WORD_W = 32;
    parameter int unsigned ADDR_W = 2;

    localparam int unsigned FLD_PER_WORD = WORD_W / FLD_W;
    localparam int unsigned ASSIGN_WORDS = (SRC_N + FLD_PER_WORD - 1) / FLD_PER_WORD;
    localparam int unsigned STATUS_ADDR  = ASSIGN_WORDS;

    typedef logic [FLD_W-1:0]            target_t;
    typedef target_t [SRC_N-1:0]         route_map_t;
    typedef logic [SRC_N-1:0]            src_vec_t;
    typedef logic [LVL_N-1:0]            lvl_vec_t;
    typedef logic [WORD_W-1:0]           word_t;
    typedef logic [ADDR_W-1:0]           addr_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_req_t;

    // Default level offset (level - 7) for each source index.
    function automatic target_t default_target(int unsigned s);
        if (s < 7)       return target_t'(0);
        else if (s < 9)  return target_t'(1);
        else if (s < 13) return target_t'(2);
        else if (s < 16) return target_t'(3);
        else if (s < 19) return target_t'(4);
        else if (s < 21) return target_t'(5);
        else             return target_t'(6);
    endfunction

    function automatic route_map_t default_map();
        route_map_t m;
        for (int unsigned s = 0; s < SRC_N; s++) begin
            m[s] = default_target(s);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_assign_regs.sv
module irq_assign_regs
    import irq_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    output route_map_t map
);

    route_map_t map_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= default_map();
        end else if (wr.en && (int'(wr.addr) < ASSIGN_WORDS)) begin
            for (int unsigned f = 0; f < FLD_PER_WORD; f++) begin
                if (int'(wr.addr) * FLD_PER_WORD + f < SRC_N) begin
                    map_q[int'(wr.addr) * FLD_PER_WORD + f] <= wr.data[f*FLD_W +: FLD_W];
                end
            end
        end
    end

    assign map = map_q;

    // R1: leaving reset always yields the default routing
    p_reset_map_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (map_q == default_map()));

    // R2: first field of a written assignment word holds the written nibble
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr.en) && (int'($past(wr.addr)) < ASSIGN_WORDS))
        |-> (map_q[int'($past(wr.addr)) * FLD_PER_WORD] == $past(wr.data[FLD_W-1:0])));

    // R8: writes outside the assignment words leave the routing untouched
    p_status_ro_r8: assert property (@(posedge clk) disable iff (rst)
        (wr.en && (int'(wr.addr) >= ASSIGN_WORDS)) |=> $stable(map_q));

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_vec_t   src,
    input  route_map_t map,
    output lvl_vec_t   lvl
);

    for (genvar l = 0; l < int'(LVL_N); l++) begin : g_level
        always_comb begin
            lvl[l] = 1'b0;
            for (int unsigned s = 0; s < SRC_N; s++) begin
                if (src[s] && (map[s] == target_t'(l))) lvl[l] = 1'b1;
            end
        end
    end

    // R4: no request in, no level out
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (lvl == '0));

    // R3: every source lands on at most one level, so lit levels never outnumber sources
    p_fanout_bound_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(lvl) <= $countones(src));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_router_pkg::*;
(
    input  addr_t      rd_addr,
    input  route_map_t map,
    input  src_vec_t   src,
    output word_t      rd_data
);

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < ASSIGN_WORDS) begin
            for (int unsigned f = 0; f < FLD_PER_WORD; f++) begin
                if (int'(rd_addr) * FLD_PER_WORD + f < SRC_N) begin
                    rd_data[f*FLD_W +: FLD_W] = map[int'(rd_addr) * FLD_PER_WORD + f];
                end
            end
        end else if (int'(rd_addr) == STATUS_ADDR) begin
            rd_data[SRC_N-1:0] = src;
        end
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [SRC_N-1:0]  src_irq,
    output logic [LVL_N-1:0]  lvl_irq
);

    wr_req_t    wr_req;
    route_map_t route_map;

    assign wr_req = '{en: wr_en, addr: wr_addr, data: wr_data};

    irq_assign_regs u_regs (
        .clk (clk),
        .rst (rst),
        .wr  (wr_req),
        .map (route_map)
    );

    irq_route_matrix u_matrix (
        .clk (clk),
        .rst (rst),
        .src (src_irq),
        .map (route_map),
        .lvl (lvl_irq)
    );

    irq_read_mux u_rd (
        .rd_addr (rd_addr),
        .map     (route_map),
        .src     (src_irq),
        .rd_data (rd_data)
    );

    // R7: status word mirrors the raw request pins
    p_status_raw_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) == STATUS_ADDR) |-> (rd_data[SRC_N-1:0] == src_irq));

endmodule

// File: tb/irq_router_test.sv
module irq_router_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [23:0] src_irq = '0;
    logic [8:0]  lvl_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .src_irq(src_irq), .lvl_irq(lvl_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    function automatic int exp_level(int s);
        if (s <= 6)  return 0;
        if (s <= 8)  return 1;
        if (s <= 12) return 2;
        if (s <= 15) return 3;
        if (s <= 18) return 4;
        if (s <= 20) return 5;
        return 6;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; src_irq = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset_defaults();
        logic [31:0] d;
        do_reset();
        reg_read(2'd0, d); chk("R1 word0", d, 32'h1000_0000);
        reg_read(2'd1, d); chk("R1 word1", d, 32'h3332_2221);
        reg_read(2'd2, d); chk("R1 word2", d, 32'h6665_5444);
        chk("R4 idle outputs", {23'b0, lvl_irq}, 32'h0);
    endtask

    task automatic t_write_readback();
        logic [31:0] d;
        do_reset();
        reg_write(2'd1, 32'h8765_4321);
        reg_read(2'd1, d); chk("R2 word1 readback", d, 32'h8765_4321);
        reg_write(2'd2, 32'h0123_4567);
        reg_read(2'd2, d); chk("R2 word2 readback", d, 32'h0123_4567);
        reg_read(2'd0, d); chk("R2 word0 untouched", d, 32'h1000_0000);
    endtask

    task automatic t_default_route();
        do_reset();
        for (int s = 0; s < 24; s++) begin
            src_irq = 24'(1) << s;
            #1;
            chk($sformatf("R3 source %0d default level", s), {23'b0, lvl_irq},
                32'(1) << exp_level(s));
        end
        src_irq = '0;
        #1;
        chk("R4 all released", {23'b0, lvl_irq}, 32'h0);
    endtask

    task automatic t_shared_level();
        do_reset();
        src_irq = 24'h07_0000;  // three timers share level 11
        #1; chk("R4 three on level 11", {23'b0, lvl_irq}, 32'h010);
        src_irq = 24'h04_0000;
        #1; chk("R4 one left on level 11", {23'b0, lvl_irq}, 32'h010);
        src_irq = 24'h84_0081;  // sources 0,7,18,23
        #1; chk("R4 mixed levels", {23'b0, lvl_irq}, 32'h053);
        src_irq = '0;
        // remap: source 0 and source 8 both to level 15
        reg_write(2'd0, 32'h1000_0008);
        reg_write(2'd1, 32'h3332_2228);
        src_irq = 24'h00_0101;
        #1; chk("R4 remapped pair on level 15", {23'b0, lvl_irq}, 32'h100);
        src_irq = '0;
    endtask

    task automatic t_write_timing();
        do_reset();
        src_irq = 24'h00_0001;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1000_0008;
        #1;
        chk("R5 old route during write cycle", {23'b0, lvl_irq}, 32'h001);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 new route after write edge", {23'b0, lvl_irq}, 32'h100);
        src_irq = '0;
    endtask

    task automatic t_route_nowhere();
        logic [31:0] d;
        do_reset();
        reg_write(2'd0, 32'hFEDC_BA99);
        src_irq = 24'h00_00FF;
        #1; chk("R6 fields 9..15 drive nothing", {23'b0, lvl_irq}, 32'h0);
        reg_read(2'd0, d); chk("R6 out-of-range fields kept", d, 32'hFEDC_BA99);
        src_irq = 24'h00_01FF;  // source 8 still at level 8
        #1; chk("R6 others unaffected", {23'b0, lvl_irq}, 32'h002);
        src_irq = '0;
    endtask

    task automatic t_status();
        logic [31:0] d;
        do_reset();
        src_irq = 24'hA5_5A3C;
        reg_read(2'd3, d); chk("R7 status pattern A", d, 32'h00A5_5A3C);
        src_irq = 24'hFF_FFFF;
        reg_read(2'd3, d); chk("R7 status all ones", d, 32'h00FF_FFFF);
        src_irq = '0;
        reg_read(2'd3, d); chk("R7 status zero", d, 32'h0);
    endtask

    task automatic t_status_read_only();
        logic [31:0] d;
        do_reset();
        reg_write(2'd3, 32'hFFFF_FFFF);
        reg_read(2'd0, d); chk("R8 word0 after status write", d, 32'h1000_0000);
        reg_read(2'd1, d); chk("R8 word1 after status write", d, 32'h3332_2221);
        reg_read(2'd2, d); chk("R8 word2 after status write", d, 32'h6665_5444);
        src_irq = 24'h00_0001;
        #1; chk("R8 routing unchanged", {23'b0, lvl_irq}, 32'h001);
        src_irq = '0;
    endtask

    initial begin
        t_reset_defaults();
        t_write_readback();
        t_default_route();
        t_shared_level();
        t_write_timing();
        t_route_nowhere();
        t_status();
        t_status_read_only();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule